// File: doc/BRIEF.md
# Four-Word Burst Address Sequencer

This block produces the word address for a synchronous memory that delivers a burst of four data words for one presented address. Each cycle a load/advance control makes one of two choices. A load captures a new external address as the start of a burst. An advance steps the low two address bits to the next word of the burst. The upper address bits stay where they are.

The burst order is chosen when the burst is loaded. In the linear order the low bits count upward from the start offset and wrap within the four-word block. In the interleaved order the low bits are the start offset XOR a step count of 0, 1, 2, 3. A stall input freezes the whole sequencer, so a burst can be paused at any word and resumed from the same position. The output is registered, so a load or an advance shows on `word_addr` in the cycle after the clock edge that samples it.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high `rst` clears `word_addr` to 0 and the step count to 0, and selects linear order. An advance after reset with no load therefore gives address 1.
- R2: When `stall`=0 and `adv`=0 at a rising edge, `word_addr` equals `ext_addr` after that edge and the step count restarts at 0. This holds for back-to-back loads as well.
- R3: The order is sampled from `order_il` only on a load: 0 selects linear, 1 selects interleaved. Changing `order_il` during advances has no effect on the sequence.
- R4: In linear order the k-th advance after a load gives low two bits (start + k) mod 4.
- R5: In interleaved order the k-th advance after a load gives low two bits start XOR (k mod 4).
- R6: During advances, `word_addr` bits above bit 1 do not change, even when the start offset is 3 and the upper bits are all ones.
- R7: The fourth advance after a load returns the low bits to the loaded start offset. The address does not carry into the upper bits.
- R8: While `stall`=1, `adv`, `order_il` and `ext_addr` are ignored. `word_addr` and the burst position are held, and the next advance after the stall continues the burst from where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | 1 freezes the sequencer and ignores the other inputs |
| adv | input | 1 | 0 loads `ext_addr`, 1 advances to the next word |
| order_il | input | 1 | Burst order sampled on load: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | Externally presented start address |
| word_addr | output | ADDR_W | Registered current word address |

## Verification
Every start offset from 0 to 3 is loaded in both orders and followed by five advances. Linear and interleaved give the same sequence for offsets 0 and 2 but different sequences for offsets 1 and 3, so the sweep tells the two mappings apart, and the fifth advance exposes any failure to wrap. A start of all ones in the address shows whether a wrap carries into the upper bits. Toggling `order_il` in the middle of a burst shows whether the order is latched on load, and a stall with junk on every other input, followed by a resume, shows whether the burst position is held. Back-to-back loads and an advance straight after reset check the restart of the step count.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_step_ctr.sv
module burst_step_ctr #(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               clear,
  output logic [BURST_W-1:0] step_q,
  output logic [BURST_W-1:0] step_nxt
);
  // next position in the burst; the natural overflow of the counter is the wrap
  assign step_nxt = step_q + BURST_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
    end else if (en) begin
      if (clear) step_q <= '0;
      else       step_q <= step_nxt;
    end
  end
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] base,
  input  logic [BURST_W-1:0] step,
  input  burst_order_e       order,
  output logic [BURST_W-1:0] offset
);
  logic [BURST_W-1:0] lin_off;
  logic [BURST_W-1:0] il_off;

  assign lin_off = base + step;

  genvar b;
  generate
    for (b = 0; b < BURST_W; b++) begin : g_il_bit
      assign il_off[b] = base[b] ^ step[b];
    end
  endgenerate

  always_comb begin
    unique case (order)
      ORD_INTERLEAVE: offset = il_off;
      default:        offset = lin_off;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              adv,
  input  logic              order_il,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int UPPER_W = ADDR_W - BURST_W;

  logic               take;
  logic               do_load;
  logic               do_adv;
  logic [BURST_W-1:0] base_q;
  burst_order_e       mode_q;
  logic [BURST_W-1:0] step_q;
  logic [BURST_W-1:0] step_nxt;
  logic [BURST_W-1:0] adv_off;
  logic [ADDR_W-1:0]  addr_q;

  assign take    = !stall;
  assign do_load = take && !adv;
  assign do_adv  = take && adv;

  burst_step_ctr #(.BURST_W(BURST_W)) u_step (
    .clk      (clk),
    .rst      (rst),
    .en       (take),
    .clear    (do_load),
    .step_q   (step_q),
    .step_nxt (step_nxt)
  );

  burst_offset_map #(.BURST_W(BURST_W)) u_map (
    .base   (base_q),
    .step   (step_nxt),
    .order  (mode_q),
    .offset (adv_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mode_q <= ORD_LINEAR;
      addr_q <= '0;
    end else if (do_load) begin
      base_q <= ext_addr[BURST_W-1:0];
      mode_q <= burst_order_e'(order_il);
      addr_q <= ext_addr;
    end else if (do_adv) begin
      addr_q <= {addr_q[ADDR_W-1 -: UPPER_W], adv_off};
    end
  end

  assign word_addr = addr_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic              adv,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] word_addr,
  input logic              mode_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> word_addr == '0)
    else $error("reset did not clear word_addr");

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !adv) |=> word_addr == $past(ext_addr))
    else $error("load did not capture ext_addr");

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && adv && !mode_q) |=>
      word_addr[BURST_W-1:0] == $past(word_addr[BURST_W-1:0]) + BURST_W'(1))
    else $error("linear advance not +1 mod burst");

  // R5
  advance_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && adv) |=> word_addr[BURST_W-1:0] != $past(word_addr[BURST_W-1:0]))
    else $error("advance left the offset unchanged");

  // R6
  upper_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && adv) |=> $stable(word_addr[ADDR_W-1:BURST_W]))
    else $error("upper bits moved during a burst");

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(word_addr))
    else $error("word_addr changed while stalled");
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stall     (stall),
  .adv       (adv),
  .ext_addr  (ext_addr),
  .word_addr (word_addr),
  .mode_q    (mode_q)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 20;
  localparam int BW = 2;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          stall;
  logic          adv;
  logic          order_il;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] word_addr;

  int      vectors = 0;
  int      fails   = 0;
  bit      done    = 0;

  // reference state
  longint  m_addr = 0;
  int      m_base = 0;
  int      m_step = 0;
  bit      m_il   = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_W(BW)) i_burst_addr_seq (
    .clk(clk), .rst(rst), .stall(stall), .adv(adv),
    .order_il(order_il), .ext_addr(ext_addr), .word_addr(word_addr)
  );

  task automatic compare(input string tag);
    vectors++;
    if (word_addr !== AW'(m_addr)) begin
      fails++;
      $display("FAIL %s: word_addr=%h expected %h", tag, word_addr, AW'(m_addr));
    end
  endtask

  task automatic apply(input bit s, input bit a, input bit o,
                       input logic [AW-1:0] x, input string tag);
    int low;
    stall = s; adv = a; order_il = o; ext_addr = x;
    @(posedge clk);
    if (!s) begin
      if (!a) begin
        m_addr = x;
        m_base = int'(x) % NW;
        m_step = 0;
        m_il   = o;
      end else begin
        m_step = (m_step + 1) % NW;
        low    = m_il ? (m_base ^ m_step) : ((m_base + m_step) % NW);
        m_addr = (m_addr / NW) * NW + low;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; stall = 0; adv = 1; order_il = 1; ext_addr = 20'h3ABCD;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare("R1 reset value");
    // R1: step cleared and linear selected: advance from 0 gives 1
    apply(0, 1, 1, 20'h0F0F0, "R1 advance after reset");

    // R4/R5/R7: every start offset in both orders
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < NW; s++) begin
        apply(0, 0, o[0], AW'(20'h5A5A0 + (s * 16) + s), "R2 load");
        for (int k = 0; k < NW - 1; k++)
          apply(0, 1, o[0], 20'h00000, o ? "R5 interleaved step" : "R4 linear step");
        apply(0, 1, o[0], 20'h00000, "R7 wrap to start");
        apply(0, 1, o[0], 20'h00000, "R7 continue after wrap");
      end
    end

    // R3: order latched on load only
    apply(0, 0, 0, 20'h12341, "R2 load");
    for (int k = 0; k < NW; k++) apply(0, 1, 1, 20'hFFFFF, "R3 linear kept");
    apply(0, 0, 1, 20'h12343, "R2 load");
    for (int k = 0; k < NW; k++) apply(0, 1, 0, 20'h00000, "R3 interleaved kept");

    // R6: no carry into upper bits
    apply(0, 0, 0, 20'hFFFFF, "R2 load");
    for (int k = 0; k < NW + 1; k++) apply(0, 1, 0, 20'h0, "R6 upper constant linear");
    apply(0, 0, 1, 20'h7FFFE, "R2 load");
    for (int k = 0; k < NW + 1; k++) apply(0, 1, 1, 20'h0, "R6 upper constant interleaved");

    // R8: stall mid-burst with junk inputs, then resume
    apply(0, 0, 1, 20'h0ACE2, "R2 load");
    apply(0, 1, 1, 20'h0, "R5 interleaved step");
    apply(1, 0, 0, 20'h55555, "R8 stall ignores load");
    apply(1, 1, 1, 20'hAAAAA, "R8 stall ignores advance");
    apply(1, 0, 1, 20'h33333, "R8 stall holds");
    for (int k = 0; k < NW; k++) apply(0, 1, 0, 20'h0, "R8 resume continues burst");
    apply(0, 0, 0, 20'h40001, "R2 load");
    apply(0, 1, 0, 20'h0, "R4 linear step");
    apply(1, 0, 1, 20'h7FFF3, "R8 stall ignores load");
    apply(0, 1, 1, 20'h0, "R8 resume linear");

    // R2: back-to-back loads restart the step count
    apply(0, 0, 0, 20'h11112, "R2 back-to-back load");
    apply(0, 0, 1, 20'h22221, "R2 back-to-back load");
    apply(0, 0, 0, 20'h33333, "R2 back-to-back load");
    apply(0, 1, 0, 20'h0, "R2 first step after reload");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule